// File: doc/BRIEF.md
# Multi-Hart Machine Timer

This block holds one free-running 64-bit time value shared by a configurable number of harts. Each hart has its own 64-bit compare register and its own timer interrupt output. The time value advances by one on every clock where the tick-enable input is high. Software can also load the time value directly through the register bus.

Each interrupt output stays equal to an unsigned comparison: the output is high when the hart's compare value is at or below the current time. The comparison is evaluated every clock, so loading a new time value re-evaluates every hart at once.

The register bus carries 32-bit or 64-bit little-endian accesses. A 64-bit register can be updated one 32-bit half at a time while the other half is kept. The bus never stalls. Every accepted request gets a response one clock later.

Top module: `mtimer_unit`

## Requirements
- R1: While reset is active, every interrupt output is low. Reset sets the time value and every compare register to zero. Because zero is at or below zero, every interrupt output goes high one clock after reset is released, as long as tick-enable is low.
- R2: When no time write occurs, the time value grows by exactly one on each clock where `tick_en` is high and holds when it is low. Carries pass from bit 31 into bit 32.
- R3: A software write to the time value in the same clock as a high `tick_en` loads the written value without the increment.
- R4: `timer_irq[i]` is high exactly when compare register i is less than or equal to the time value, compared as unsigned 64-bit numbers. The output is registered, so it shows the comparison one clock after either operand changes.
- R5: A write to the time value, whether full, low half or high half, re-evaluates every hart's interrupt against that hart's unchanged compare value.
- R6: Compare register i sits at byte address `CMP_BASE + 8*i`. Its low half is at offset 0 and its high half at offset 4. The time value sits at `TIME_BASE`, with the same half layout.
- R7: A 32-bit write (`req_size8`=0) to offset 0 replaces only bits 31:0 of the register. A 32-bit write to offset 4 replaces only bits 63:32, taking the new value from `req_wdata[31:0]`. In both cases the other half is kept.
- R8: A 64-bit write (`req_size8`=1) to offset 0 replaces the whole register from `req_wdata[63:0]`.
- R9: A 64-bit write aimed at offset 4 of any register is ignored.
- R10: Every request is accepted (`req_ready`=1), and `rsp_valid` is high one clock after `req_valid`. For a read, `rsp_rdata` returns the following:
  - a 64-bit read at offset 0 returns the whole register;
  - a 32-bit read at offset 0 returns bits 31:0 with zero extension;
  - any read at offset 4 returns bits 63:32 with zero extension.
- R11: An address is unmapped if it hits no register, or if bits 1:0 are not zero. A read of an unmapped address returns zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Advance the time value by one this clock |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size8 | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Write data, little-endian |
| rsp_valid | output | 1 | Response for the previous clock's request |
| rsp_rdata | output | 64 | Read data (zero for writes) |
| timer_irq | output | NUM_HARTS | Per-hart timer interrupt level |

## Verification
The hardest situation to reach from the ports is a comparison decided only in the upper half of the 64-bit values. In that case the time crosses a 32-bit boundary, or a split write leaves a half-old, half-new register. The bench places the time at 2^32 with full and half writes. It then sweeps every hart's compare value through one below, equal to and one above that time, and checks each interrupt bit. It also drives a tick run across the bit-31 carry and a half write to the time value that flips several harts at once.

// File: rtl/mtimer_pkg.sv
`timescale 1ns/1ps
package mtimer_pkg;

   localparam int unsigned REG_W  = 64;
   localparam int unsigned HALF_W = 32;

   // Which halves of a 64-bit register a write replaces
   typedef struct packed {
      logic hi;
      logic lo;
   } half_sel_t;

   // Merge write data into an existing register value.
   // A 32-bit write to the high half takes its data from wdata[31:0].
   function automatic logic [REG_W-1:0] merge_halves(
      input logic [REG_W-1:0] old_val,
      input logic [REG_W-1:0] wdata,
      input half_sel_t        sel,
      input logic             size8
   );
      logic [HALF_W-1:0] new_hi;
      logic [HALF_W-1:0] new_lo;
      new_hi = size8 ? wdata[REG_W-1:HALF_W] : wdata[HALF_W-1:0];
      new_lo = wdata[HALF_W-1:0];
      return {sel.hi ? new_hi : old_val[REG_W-1:HALF_W],
              sel.lo ? new_lo : old_val[HALF_W-1:0]};
   endfunction

endpackage

// File: rtl/mtimer_decode.sv
`timescale 1ns/1ps
module mtimer_decode
   import mtimer_pkg::*;
#(
   parameter int unsigned NUM_HARTS = 4,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned CMP_BASE  = 32'h4000,
   parameter int unsigned TIME_BASE = 32'hBFF8,
   localparam int unsigned IDX_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              size8,
   output logic              cmp_hit,
   output logic [IDX_W-1:0]  cmp_idx,
   output logic              time_hit,
   output logic              off_hi,
   output half_sel_t         wr_sel
);

   localparam logic [31:0] CMP_LO  = CMP_BASE;
   localparam logic [31:0] CMP_END = CMP_BASE + NUM_HARTS * 8;
   localparam logic [31:0] TIME_LO = TIME_BASE;

   logic [31:0] a32;
   logic [31:0] cmp_rel;
   logic        aligned4;

   always_comb begin
      a32      = 32'(addr);
      cmp_rel  = a32 - CMP_LO;
      aligned4 = (a32[1:0] == 2'b00);
      cmp_hit  = aligned4 && (a32 >= CMP_LO) && (a32 < CMP_END);
      cmp_idx  = cmp_rel[IDX_W+2:3];
      time_hit = aligned4 && (a32[31:3] == TIME_LO[31:3]);
      off_hi   = a32[2];
      // 64-bit at offset 0: both halves; 64-bit at offset 4: none
      if (size8) begin
         wr_sel.lo = !off_hi;
         wr_sel.hi = !off_hi;
      end else begin
         wr_sel.lo = !off_hi;
         wr_sel.hi = off_hi;
      end
   end

endmodule

// File: rtl/mtimer_count.sv
`timescale 1ns/1ps
module mtimer_count
   import mtimer_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             wr_en,
   input  half_sel_t        wr_sel,
   input  logic             wr_size8,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] time_q
);

   logic wr_any;
   assign wr_any = wr_en && (wr_sel.lo || wr_sel.hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         time_q <= '0;
      end else if (wr_any) begin
         time_q <= merge_halves(time_q, wdata, wr_sel, wr_size8);
      end else if (tick_en) begin
         time_q <= time_q + 64'd1;
      end
   end

   p_time_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_any && tick_en) |=> (time_q == $past(time_q) + 64'd1));

   p_time_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_any && !tick_en) |=> $stable(time_q));

   p_time_write_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_size8 && wr_sel.lo && wr_sel.hi) |=> (time_q == $past(wdata)));

endmodule

// File: rtl/mtimer_cmp_slot.sv
`timescale 1ns/1ps
module mtimer_cmp_slot
   import mtimer_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  half_sel_t        wr_sel,
   input  logic             wr_size8,
   input  logic [REG_W-1:0] wdata,
   input  logic [REG_W-1:0] time_q,
   output logic [REG_W-1:0] cmp_q,
   output logic             irq_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
      end else if (wr_en) begin
         cmp_q <= merge_halves(cmp_q, wdata, wr_sel, wr_size8);
      end
   end

   // Registered level: one clock behind the operands
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= (cmp_q <= time_q);
   end

   p_cmp_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cmp_q));

   p_ignored_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel.lo && !wr_sel.hi) |=> $stable(cmp_q));

endmodule

// File: rtl/mtimer_unit.sv
`timescale 1ns/1ps
module mtimer_unit
   import mtimer_pkg::*;
#(
   parameter int unsigned NUM_HARTS = 4,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned CMP_BASE  = 32'h4000,
   parameter int unsigned TIME_BASE = 32'hBFF8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_en,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_write,
   input  logic                 req_size8,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [63:0]          req_wdata,
   output logic                 rsp_valid,
   output logic [63:0]          rsp_rdata,
   output logic [NUM_HARTS-1:0] timer_irq
);

   localparam int unsigned IDX_W   = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;
   localparam longint unsigned CMP_END = longint'(CMP_BASE) + NUM_HARTS * 8;

   // Elaboration-time parameter checks
   generate
      if (NUM_HARTS < 1 || NUM_HARTS > 4096) begin : g_bad_harts
         $error("mtimer_unit: NUM_HARTS out of range");
      end
      if (ADDR_W < 4 || ADDR_W > 32) begin : g_bad_aw
         $error("mtimer_unit: ADDR_W must be 4..32");
      end
      if ((CMP_BASE % 8) != 0 || (TIME_BASE % 8) != 0) begin : g_bad_align
         $error("mtimer_unit: bases must be 8-byte aligned");
      end
      if (TIME_BASE >= CMP_BASE && longint'(TIME_BASE) < CMP_END) begin : g_overlap
         $error("mtimer_unit: time register overlaps compare block");
      end
   endgenerate

   logic             cmp_hit, time_hit, off_hi;
   logic [IDX_W-1:0] cmp_idx;
   half_sel_t        wr_sel;
   logic             wr_cycle;
   logic [REG_W-1:0] time_q;
   logic [REG_W-1:0] cmp_q [NUM_HARTS];
   logic [REG_W-1:0] rd_src, rd_next;

   assign req_ready = 1'b1;
   assign wr_cycle  = req_valid && req_write;

   mtimer_decode #(
      .NUM_HARTS (NUM_HARTS),
      .ADDR_W    (ADDR_W),
      .CMP_BASE  (CMP_BASE),
      .TIME_BASE (TIME_BASE)
   ) u_decode (
      .addr     (req_addr),
      .size8    (req_size8),
      .cmp_hit  (cmp_hit),
      .cmp_idx  (cmp_idx),
      .time_hit (time_hit),
      .off_hi   (off_hi),
      .wr_sel   (wr_sel)
   );

   mtimer_count u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .wr_en    (wr_cycle && time_hit),
      .wr_sel   (wr_sel),
      .wr_size8 (req_size8),
      .wdata    (req_wdata),
      .time_q   (time_q)
   );

   for (genvar h = 0; h < NUM_HARTS; h++) begin : g_slot
      mtimer_cmp_slot u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr_cycle && cmp_hit && (cmp_idx == IDX_W'(h))),
         .wr_sel   (wr_sel),
         .wr_size8 (req_size8),
         .wdata    (req_wdata),
         .time_q   (time_q),
         .cmp_q    (cmp_q[h]),
         .irq_q    (timer_irq[h])
      );
   end

   // Read path
   always_comb begin
      rd_src = '0;
      if (time_hit)     rd_src = time_q;
      else if (cmp_hit) rd_src = cmp_q[cmp_idx];
      if (req_size8 && !off_hi) rd_next = rd_src;
      else if (off_hi)          rd_next = {32'd0, rd_src[63:32]};
      else                      rd_next = {32'd0, rd_src[31:0]};
      if (req_write || !req_valid) rd_next = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_rdata <= rd_next;
      end
   end

   p_rsp_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_no_spurious_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && !cmp_hit && !time_hit) |=> (rsp_rdata == 64'd0));

   p_time_wr_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cycle && time_hit && !req_size8 && !off_hi && (time_q[63:32] == 32'd0)
       && (cmp_q[0] == 64'd0)) |=> ##1 timer_irq[0]);

endmodule

// File: tb/mtimer_unit_test.sv
`timescale 1ns/1ps
module mtimer_unit_test;

   localparam int unsigned NH = 4;
   localparam int unsigned AW = 16;
   localparam logic [15:0] CB = 16'h4000;
   localparam logic [15:0] TB = 16'hBFF8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic          req_size8 = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [63:0]   req_wdata = '0;
   logic          rsp_valid;
   logic [63:0]   rsp_rdata;
   logic [NH-1:0] timer_irq;

   int n_cmp = 0;
   int n_bad = 0;
   logic [63:0] m_time;
   logic [63:0] m_cmp [NH];

   always #2 clk = ~clk;

   mtimer_unit #(.NUM_HARTS(NH), .ADDR_W(AW), .CMP_BASE(32'h4000), .TIME_BASE(32'hBFF8)) uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_size8(req_size8), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .timer_irq(timer_irq)
   );

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // Model of a write, from R6..R11
   task automatic mdl_write(input logic [15:0] a, input logic s8, input logic [63:0] d);
      logic [63:0] old;
      logic        is_t, is_c;
      int          idx;
      if (a[1:0] != 2'b00) return;
      is_t = (a[15:3] == TB[15:3]);
      is_c = (a >= CB) && (a < CB + 16'(NH*8));
      if (!is_t && !is_c) return;
      idx = int'((a - CB) >> 3);
      old = is_t ? m_time : m_cmp[idx];
      if (s8 && !a[2])       old = d;
      else if (s8 && a[2])   return;
      else if (!a[2])        old[31:0] = d[31:0];
      else                   old[63:32] = d[31:0];
      if (is_t) m_time = old; else m_cmp[idx] = old;
   endtask

   task automatic wr(input logic [15:0] a, input logic s8, input logic [63:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_size8 = s8; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      mdl_write(a, s8, d);
      chk("R10 write response valid", {63'd0, rsp_valid}, 64'd1);
   endtask

   task automatic rd(input logic [15:0] a, input logic s8, output logic [63:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_size8 = s8; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      d = rsp_rdata;
   endtask

   task automatic irq_chk(input string tag);
      logic [NH-1:0] e;
      @(negedge clk);
      for (int i = 0; i < NH; i++) e[i] = (m_cmp[i] <= m_time);
      chk(tag, 64'(timer_irq), 64'(e));
   endtask

   task automatic tick(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
      m_time = m_time + 64'(n);
   endtask

   initial begin : wd
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [63:0] v;
      m_time = '0;
      for (int i = 0; i < NH; i++) m_cmp[i] = '0;

      // R1: reset
      repeat (3) @(negedge clk);
      chk("R1 irq low in reset", 64'(timer_irq), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R1 irq high after reset (0<=0)", 64'(timer_irq), 64'hF);
      rd(TB, 1'b1, v);       chk("R1 time zero", v, 64'd0);
      rd(CB + 16'd8, 1'b1, v); chk("R1 compare zero", v, 64'd0);
      chk("R10 req_ready", {63'd0, req_ready}, 64'd1);

      // R2: ticking and carry across halves
      tick(5);
      rd(TB, 1'b1, v); chk("R2 five ticks", v, m_time);
      wr(TB, 1'b1, 64'h0000_0000_FFFF_FFFE);
      tick(3);
      rd(TB, 1'b1, v); chk("R2 carry into high half", v, 64'h0000_0001_0000_0001);
      rd(TB + 16'd4, 1'b0, v); chk("R10 32-bit high read", v, 64'h1);
      rd(TB + 16'd4, 1'b1, v); chk("R10 64-bit read at offset 4", v, 64'h1);
      rd(TB, 1'b0, v); chk("R10 32-bit low read", v, 64'h1);

      // R3: write beats tick
      @(negedge clk);
      tick_en = 1'b1;
      req_valid = 1'b1; req_write = 1'b1; req_size8 = 1'b1; req_addr = TB;
      req_wdata = 64'h1234_5678_9ABC_DEF0;
      @(negedge clk);
      tick_en = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      m_time = 64'h1234_5678_9ABC_DEF0;
      rd(TB, 1'b1, v); chk("R3 write wins over tick", v, m_time);

      // R4/R6/R8: sweep each hart around a time of 2^32
      for (int h = 0; h < NH; h++) begin
         for (int d = 0; d < 3; d++) begin
            wr(TB, 1'b0, 64'h0);
            wr(TB + 16'd4, 1'b0, 64'h1);
            wr(CB + 16'(h*8), 1'b1, 64'h0000_0001_0000_0000 + 64'(d) - 64'd1);
            irq_chk($sformatf("R4 hart %0d delta %0d", h, d));
            rd(CB + 16'(h*8), 1'b1, v);
            chk($sformatf("R8 R6 readback hart %0d", h), v, m_cmp[h]);
            rd(CB + 16'(h*8) + 16'd4, 1'b0, v);
            chk($sformatf("R10 R6 high half hart %0d", h), v, {32'd0, m_cmp[h][63:32]});
         end
      end

      // R7: half writes keep the other half
      wr(CB + 16'd8, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD);
      wr(CB + 16'd8, 1'b0, 64'hFFFF_FFFF_1111_2222);
      rd(CB + 16'd8, 1'b1, v); chk("R7 low-half write", v, 64'hAAAA_BBBB_1111_2222);
      wr(CB + 16'd12, 1'b0, 64'hFFFF_FFFF_3333_4444);
      rd(CB + 16'd8, 1'b1, v); chk("R7 high-half write", v, 64'h3333_4444_1111_2222);

      // R9: 64-bit write at offset 4 ignored
      wr(CB + 16'd12, 1'b1, 64'h5555_6666_7777_8888);
      rd(CB + 16'd8, 1'b1, v); chk("R9 ignored compare write", v, 64'h3333_4444_1111_2222);
      wr(TB + 16'd4, 1'b1, 64'h5555_6666_7777_8888);
      rd(TB, 1'b1, v); chk("R9 ignored time write", v, m_time);

      // R5: time writes re-evaluate all harts
      wr(TB, 1'b1, 64'd0);
      for (int i = 0; i < NH; i++) wr(CB + 16'(i*8), 1'b1, 64'(10 * (i + 1)));
      irq_chk("R5 none pending at time 0");
      wr(TB, 1'b0, 64'd25);
      irq_chk("R5 low-half time write flips two harts");
      chk("R5 pattern", 64'(timer_irq), 64'h3);
      wr(TB + 16'd4, 1'b0, 64'd1);
      irq_chk("R5 high-half time write flips all");
      wr(TB, 1'b1, 64'd0);
      irq_chk("R5 full time write clears all");

      // R11: unmapped accesses
      rd(16'h0100, 1'b1, v);            chk("R11 unmapped read", v, 64'd0);
      rd(CB + 16'd1, 1'b0, v);          chk("R11 misaligned read", v, 64'd0);
      rd(CB + 16'(NH*8), 1'b1, v);      chk("R11 read past last compare", v, 64'd0);
      wr(16'h0100, 1'b1, 64'hDEAD_BEEF_DEAD_BEEF);
      wr(TB + 16'd2, 1'b0, 64'hFFFF_FFFF);
      wr(CB + 16'(NH*8), 1'b1, 64'h0);
      rd(TB, 1'b1, v); chk("R11 time untouched", v, 64'd0);
      for (int i = 0; i < NH; i++) begin
         rd(CB + 16'(i*8), 1'b1, v);
         chk($sformatf("R11 compare %0d untouched", i), v, m_cmp[i]);
      end
      irq_chk("R11 irq untouched");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule